// File: doc/BRIEF.md
# Byte-wide ROM word assembler

This block builds a 16-bit read word out of a ROM that is only one byte wide. The word address comes straight from the bus. The lowest byte-address bit is not taken from the bus: the block generates it locally. A read strobe starts a fixed sequence of steps:

- The internal byte select holds low, and the ROM returns the low byte of the word.
- On a single clock edge, the byte select rises. At that same edge the low byte is stored in a holding register, and the ROM address moves to the high byte.
- A fixed number of cycles after the start, the output enable rises and the assembled word is driven.
- A further fixed delay later, a completion signal is raised, which serves as the slave acknowledge.

The ROM is modelled as a synchronous byte array with one cycle of latency. Its contents are computed. When the read strobe is dropped, the whole sequence returns to idle. A new read needs the strobe to be low for at least one cycle first.

Top module: `rom_word_asm`

## Requirements
- R1: The ROM byte at byte address b is (b*29 + 7) mod 256. Word address a reads byte address 2a (byte select low) and byte address 2a+1 (byte select high). Only the word address comes from the port.
- R2: `byte_sel_o` is low while no read is in progress. It stays low in the first cycle after the edge that starts a read.
- R3: `byte_sel_o` rises at the second clock edge of a read. The ROM byte of the low half is captured at that same edge.
- R4: While enabled, `data_o[7:0]` is the captured byte 2a and `data_o[15:8]` is the byte 2a+1 read directly from the ROM.
- R5: `data_en_o` rises at clock edge EN_CYC of a read, counting the start edge as edge 1 (default 4; values below 3 act as 3).
- R6: `ack_o` rises ACK_CYC edges after `data_en_o` (default 3, so edge 7). It is never high while `data_en_o` is low.
- R7: `data_o` is all zeros whenever `data_en_o` is low.
- R8: Once `rd_req_i` is sampled low at an edge, `byte_sel_o`, `data_en_o` and `ack_o` are all low after that edge, even in the middle of a read.
- R9: While `rd_req_i` stays high after the acknowledge, `ack_o`, `data_en_o` and `data_o` hold their values, and no second read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read strobe, held high for the whole read |
| word_addr_i | input | ADDR_W (7) | Word address, held stable while the strobe is high |
| data_o | output | 2*BYTE_W (16) | Assembled word, zero when not enabled |
| data_en_o | output | 1 | Output data enabled |
| ack_o | output | 1 | Read complete (slave acknowledge) |
| byte_sel_o | output | 1 | Locally generated byte-address bit 0 |

## Verification
Reads are issued at the lowest and highest word addresses and at alternating-bit addresses. Because every byte value differs from its neighbours, a swapped half, a missed capture, or the wrong byte select shows up as a wrong word. Every cycle of each read is compared with the expected edge count for the byte select, the enable and the acknowledge, which tells an off-by-one delay apart from a wrong ordering. Aborts at several points in the sequence, and a strobe held past the acknowledge, separate a proper return to idle from a stuck or restarting sequence.

// File: rtl/rom_word_pkg.sv
package rom_word_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_DRIVE,
    ST_DONE
  } seq_state_e;

  // computed ROM image: byte b holds (b*29 + 7) truncated to the byte width
  function automatic logic [7:0] rom_image(input logic [15:0] b);
    logic [15:0] v;
    v = b * 16'd29 + 16'd7;
    return v[7:0];
  endfunction

endpackage

// File: rtl/rwa_byte_rom.sv
module rwa_byte_rom #(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic              sel_i,
  output logic [BYTE_W-1:0] rom_q_o
);
  import rom_word_pkg::*;

  localparam int BA_W = ADDR_W + 1;

  logic [BA_W-1:0]   byte_addr;
  logic [15:0]       byte_addr_ext;
  logic [7:0]        img_byte;
  logic [BYTE_W-1:0] rd_byte;

  assign byte_addr     = {word_addr_i, sel_i};
  assign byte_addr_ext = 16'(byte_addr);
  assign img_byte      = rom_image(byte_addr_ext);

  generate
    if (BYTE_W <= 8) begin : g_narrow
      assign rd_byte = img_byte[BYTE_W-1:0];
    end else begin : g_wide
      assign rd_byte = {{(BYTE_W-8){1'b0}}, img_byte};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rom_q_o <= '0;
    else         rom_q_o <= rd_byte;
  end

endmodule

// File: rtl/rwa_seq.sv
module rwa_seq #(
  parameter int EN_CYC  = 4,
  parameter int ACK_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  output logic sel_o,
  output logic capture_o,
  output logic en_o,
  output logic ack_o
);
  import rom_word_pkg::*;

  localparam int EN_EFF  = (EN_CYC < 3) ? 3 : EN_CYC;
  localparam int ACK_EFF = (ACK_CYC < 1) ? 1 : ACK_CYC;
  localparam int LAST    = EN_EFF + ACK_EFF;
  localparam int CNT_W   = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] EN_AT  = CNT_W'(EN_EFF - 1);
  localparam logic [CNT_W-1:0] ACK_AT = CNT_W'(LAST - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] tick_q;
  logic             sel_q, en_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      sel_q   <= 1'b0;
      en_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else if (!rd_req_i) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      sel_q   <= 1'b0;
      en_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_LOW;
          tick_q  <= CNT_W'(1);
        end
        ST_LOW: begin
          // low byte now valid at the ROM output: capture and switch
          state_q <= ST_HIGH;
          sel_q   <= 1'b1;
          tick_q  <= tick_q + 1'b1;
        end
        ST_HIGH: begin
          tick_q <= tick_q + 1'b1;
          if (tick_q == EN_AT) begin
            state_q <= ST_DRIVE;
            en_q    <= 1'b1;
          end
        end
        ST_DRIVE: begin
          tick_q <= tick_q + 1'b1;
          if (tick_q == ACK_AT) begin
            state_q <= ST_DONE;
            ack_q   <= 1'b1;
          end
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_o     = sel_q;
  assign capture_o = (state_q == ST_LOW) && rd_req_i;
  assign en_o      = en_q;
  assign ack_o     = ack_q;

  assert_sel_rise_from_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_q) |-> $past(state_q) == ST_LOW);

  assert_idle_sel_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_LOW) |-> !sel_q);

  assert_ack_needs_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> en_q);

endmodule

// File: rtl/rwa_hold.sv
module rwa_hold #(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic                en_i,
  input  logic [BYTE_W-1:0]   rom_q_i,
  output logic [2*BYTE_W-1:0] data_o
);

  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= '0;
    else if (capture_i) hold_q <= rom_q_i;
  end

  assign data_o = en_i ? {rom_q_i, hold_q} : '0;

  assert_capture_low_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(capture_i) |-> hold_q == $past(rom_q_i));

endmodule

// File: rtl/rom_word_asm.sv
module rom_word_asm #(
  parameter int ADDR_W  = 7,
  parameter int BYTE_W  = 8,
  parameter int EN_CYC  = 4,
  parameter int ACK_CYC = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_req_i,
  input  logic [ADDR_W-1:0]   word_addr_i,
  output logic [2*BYTE_W-1:0] data_o,
  output logic                data_en_o,
  output logic                ack_o,
  output logic                byte_sel_o
);

  logic              sel, capture, en, ack;
  logic [BYTE_W-1:0] rom_q;

  rwa_seq #(.EN_CYC(EN_CYC), .ACK_CYC(ACK_CYC)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_req_i (rd_req_i),
    .sel_o    (sel),
    .capture_o(capture),
    .en_o     (en),
    .ack_o    (ack)
  );

  rwa_byte_rom #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_rom (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_addr_i(word_addr_i),
    .sel_i      (sel),
    .rom_q_o    (rom_q)
  );

  rwa_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .en_i     (en),
    .rom_q_i  (rom_q),
    .data_o   (data_o)
  );

  assign data_en_o  = en;
  assign ack_o      = ack;
  assign byte_sel_o = sel;

  assert_drop_idles_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> (!byte_sel_o && !data_en_o && !ack_o));

  assert_en_after_switch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_en_o) |-> byte_sel_o && $past(byte_sel_o));

  assert_quiet_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_en_o |-> data_o == '0);

  assert_ack_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ack_o) && rd_req_i && $past(rd_req_i)) |-> ack_o && $stable(data_o));

endmodule

// File: tb/tb_rom_word_asm.sv
module tb_rom_word_asm;

  localparam int CLK_PERIOD = 10;
  localparam int EN_CYC  = 4;
  localparam int ACK_CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] data;
  logic        data_en, ack, bsel;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_q[$];
  logic        ack_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_word_asm #(.ADDR_W(7), .BYTE_W(8), .EN_CYC(EN_CYC), .ACK_CYC(ACK_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .word_addr_i(addr),
    .data_o(data), .data_en_o(data_en), .ack_o(ack), .byte_sel_o(bsel)
  );

  function automatic logic [7:0] img(input int b);
    return 8'((b * 29 + 7) % 256);
  endfunction

  function automatic logic [15:0] word_of(input logic [6:0] a);
    return {img(2*a + 1), img(2*a)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compare the word on each rising acknowledge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack && !ack_prev) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected ack", 32'(data), 32'hx);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(data == e, "R1/R4 word", 32'(data), 32'(e));
        end
      end
      ack_prev <= ack;
    end
  end

  // abort_at = 0: full read, then strobe held 3 cycles past ack (R9)
  task automatic read_word(input logic [6:0] a, input int abort_at);
    logic [15:0] e;
    int last;
    e = word_of(a);
    @(negedge clk);
    addr = a;
    rd_req = 1'b1;
    if (abort_at == 0) exp_q.push_back(e);
    last = (abort_at == 0) ? EN_CYC + ACK_CYC + 3 : abort_at;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      chk(bsel == (k >= 2), (k < 2) ? "R2 sel low at start" : "R3 sel high", 32'(bsel), 32'(k >= 2));
      chk(data_en == (k >= EN_CYC), "R5 enable edge", 32'(data_en), 32'(k >= EN_CYC));
      chk(ack == (k >= EN_CYC + ACK_CYC), "R6 ack edge", 32'(ack), 32'(k >= EN_CYC + ACK_CYC));
      if (!data_en) chk(data == 16'h0, "R7 data zero", 32'(data), 32'h0);
      else if (k > EN_CYC + ACK_CYC) chk(data == e, "R9 data held", 32'(data), 32'(e));
      else chk(data == e, "R4 word order", 32'(data), 32'(e));
    end
    rd_req = 1'b0;
    @(negedge clk);
    chk(!bsel && !data_en && !ack, "R8 return to idle",
        32'({bsel, data_en, ack}), 32'h0);
    chk(data == 16'h0, "R7 data zero after drop", 32'(data), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(data == 0 && !data_en && !ack && !bsel, "R2 reset state",
        32'({data, data_en, ack, bsel}), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bsel && !data_en && !ack, "R2 idle quiet", 32'({bsel, data_en, ack}), 32'h0);

    read_word(7'h00, 0);
    read_word(7'h7f, 0);
    read_word(7'h55, 0);
    read_word(7'h2a, 0);
    read_word(7'h13, 2);  // R8 abort after switch
    read_word(7'h14, 1);  // R8 abort before switch
    read_word(7'h15, EN_CYC + 1); // R8 abort while enabled
    read_word(7'h40, 0);
    for (int i = 0; i < 6; i++) read_word(7'(i * 21 + 3), 0);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all reads acknowledged", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule